// File: doc/BRIEF.md
# Hamming-Protected Parallel FIR Filter Bank

This block runs four identical four-tap FIR filters side by side, one per input stream, all sharing a single fixed coefficient set. Next to them run three redundant filters with the same coefficients. Each redundant filter is fed the sum of three of the four input streams, following a (7,4) Hamming arrangement. Convolution is linear, so every redundant output must equal the sum of the matching main outputs. Each sample cycle the block compares the two. The pattern of mismatches points to at most one failed filter, and that filter's output is rebuilt from a redundant output minus the healthy main outputs.

All seven filters share one sample-valid strobe and have the same pipeline depth. The comparison therefore always relates results of the same sample. An error flag reports any mismatch. A set of XOR masks, one per filter output, lets a test corrupt any single filter without touching the arithmetic. The integer arithmetic is exact, with accumulators wide enough for full precision, so an equality test is a sound check.

Top module: `parity_fir_bank`

## Requirements
- R1: A synchronous active-low reset clears the filter histories to zero and drives out_valid and err_o low on the next edge.
- R2: Each main output y_o[j] equals h0·x[n] + h1·x[n−1] + h2·x[n−2] + h3·x[n−3] over the last four accepted samples of x_i[j], with history zero after reset. Lane j=0 is the first stream. The default coefficients are h0=5, h1=−77, h2=1234, h3=−32768, with all values signed two's complement.
- R3: A sample accepted at clock edge E appears on y_o, with out_valid high, after edge E+3. out_valid is low after edge E+2 when no sample was accepted at E−1. out_valid is in_valid delayed by four edges.
- R4: While in_valid is low, no filter history advances, so y_o keeps its values.
- R5: With all fault masks zero, err_o stays low and y_o matches R2.
- R6: A nonzero mask on exactly one main output (yfault_i[j]) still yields correct y_o for all four lanes, with err_o high. The three check filters sum lanes {0,1,2}, {0,1,3} and {0,2,3}.
- R7: A nonzero mask on exactly one redundant output (zfault_i[i]) leaves y_o correct and raises err_o.
- R8: Full-scale inputs (−32768 and 32767) together with the −32768 coefficient give exact outputs, and the parity check does not misfire.
- R9: err_o is high only in cycles where out_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Shared sample strobe for all four streams |
| x_i | input | 4×16 | Input samples, element j is stream j |
| yfault_i | input | 4×34 | Test XOR masks on the main filter outputs |
| zfault_i | input | 3×36 | Test XOR masks on the redundant filter outputs |
| out_valid | output | 1 | Corrected outputs belong to a new sample |
| y_o | output | 4×34 | Corrected filter outputs |
| err_o | output | 1 | A mismatch was seen for this sample |

## Verification
Every result of a sample is due three edges after the edge that accepts it: the tap, product, accumulator and correction registers each add one. The bench drives each sample on a falling edge and then drops in_valid. It checks that out_valid is still low at the falling edge before the third following rising edge. At the falling edge after that rising edge it checks the corrected outputs, the flag and the valid together. Fault masks are held constant from the drive until that check, so the flag and the correction always refer to one sample.

// File: rtl/pfb_pkg.sv
// Shared constants for the parity-protected FIR bank.
// Assumes a (7,4) arrangement: four data lanes, three check lanes.
package pfb_pkg;
    localparam int NMAIN = 4;
    localparam int NPAR  = 3;
    // Lane membership of each check filter; bit j set means data lane j is summed.
    localparam logic [NMAIN-1:0] MEMBERS [NPAR] = '{4'b0111, 4'b1011, 4'b1101};
endpackage

// File: rtl/pfb_fir_lane.sv
// One pipelined FIR lane with fixed coefficients.
// Taps advance only on adv; product and sum registers run every cycle.
// Latency: tap (edge 0), products (edge 1), accumulator (edge 2).
module pfb_fir_lane #(
    parameter int IW    = 16,
    parameter int CW    = 16,
    parameter int NTAP  = 4,
    parameter logic [NTAP*CW-1:0] COEFS = '0,
    localparam int PW = IW + CW,
    localparam int AW = PW + $clog2(NTAP)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic signed [IW-1:0] x,
    output logic signed [AW-1:0] y
);
    logic signed [IW-1:0] tap  [NTAP];
    logic signed [PW-1:0] prod [NTAP];
    logic signed [AW-1:0] sum_c;

    // Shift the sample history on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAP; k++) tap[k] <= '0;
        end else if (adv) begin
            tap[0] <= x;
            for (int k = 1; k < NTAP; k++) tap[k] <= tap[k-1];
        end
    end

    generate
        for (genvar k = 0; k < NTAP; k++) begin : g_tap
            localparam logic signed [CW-1:0] HK = COEFS[k*CW +: CW];
            // Register one tap product.
            always_ff @(posedge clk) begin
                if (!rst_n) prod[k] <= '0;
                else        prod[k] <= tap[k] * HK;
            end
        end
    endgenerate

    // Add all products at full precision.
    always_comb begin
        sum_c = '0;
        for (int k = 0; k < NTAP; k++)
            sum_c = sum_c + {{(AW-PW){prod[k][PW-1]}}, prod[k]};
    end

    // Register the accumulated result.
    always_ff @(posedge clk) begin
        if (!rst_n) y <= '0;
        else        y <= sum_c;
    end
endmodule

// File: rtl/pfb_parity_encode.sv
// Forms the check-filter inputs as sums of member data samples.
// Assumes ZW >= DW + 2 so a sum of three samples cannot overflow.
module pfb_parity_encode #(
    parameter int DW = 16,
    parameter int ZW = DW + 2
) (
    input  logic [pfb_pkg::NMAIN-1:0][DW-1:0] x,
    output logic [pfb_pkg::NPAR-1:0][ZW-1:0]  zin
);
    import pfb_pkg::*;

    // Sum sign-extended member samples for each check lane.
    always_comb begin
        for (int i = 0; i < NPAR; i++) begin
            zin[i] = '0;
            for (int j = 0; j < NMAIN; j++)
                if (MEMBERS[i][j]) zin[i] = zin[i] + {{(ZW-DW){x[j][DW-1]}}, x[j]};
        end
    end
endmodule

// File: rtl/pfb_syndrome_fix.sv
// Compares check outputs with sums of data outputs, decodes the
// syndrome to one faulty data lane and rebuilds it by subtraction.
// Assumes at most one faulty output per sample; adds one register stage.
module pfb_syndrome_fix #(
    parameter int YW = 34,
    parameter int ZW = 36
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               vld,
    input  logic [pfb_pkg::NMAIN-1:0][YW-1:0]  y,
    input  logic [pfb_pkg::NPAR-1:0][ZW-1:0]   z,
    output logic [pfb_pkg::NMAIN-1:0][YW-1:0]  y_fix,
    output logic                               err,
    output logic                               vld_o
);
    import pfb_pkg::*;

    logic [NPAR-1:0]              syn;
    logic [NMAIN-1:0][YW-1:0]     fixed;
    logic signed [ZW-1:0]         acc;
    logic signed [ZW-1:0]         rebuilt;
    logic [NPAR-1:0]              col;
    int                           sel;

    // Syndrome: one bit per check lane, set on any arithmetic mismatch.
    always_comb begin
        syn = '0;
        acc = '0;
        for (int i = 0; i < NPAR; i++) begin
            acc = '0;
            for (int j = 0; j < NMAIN; j++)
                if (MEMBERS[i][j]) acc = acc + {{(ZW-YW){y[j][YW-1]}}, y[j]};
            syn[i] = (acc != z[i]);
        end
    end

    // Locate the lane whose membership column matches and rebuild it.
    always_comb begin
        rebuilt = '0;
        col     = '0;
        sel     = 0;
        for (int j = 0; j < NMAIN; j++) begin
            fixed[j] = y[j];
            for (int i = 0; i < NPAR; i++) col[i] = MEMBERS[i][j];
            sel = 0;
            for (int i = NPAR-1; i >= 0; i--)
                if (MEMBERS[i][j]) sel = i;
            if (syn == col) begin
                rebuilt = z[sel];
                for (int m = 0; m < NMAIN; m++)
                    if (m != j && MEMBERS[sel][m])
                        rebuilt = rebuilt - {{(ZW-YW){y[m][YW-1]}}, y[m]};
                fixed[j] = rebuilt[YW-1:0];
            end
        end
    end

    // Register corrected outputs, flag and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_fix <= '0;
            err   <= 1'b0;
            vld_o <= 1'b0;
        end else begin
            y_fix <= fixed;
            err   <= vld & (|syn);
            vld_o <= vld;
        end
    end
endmodule

// File: rtl/parity_fir_bank.sv
// Four parallel FIR filters protected by three check filters in a
// (7,4) arrangement. Any single faulty filter output is detected and
// the four data outputs are delivered corrected. Latency is four edges.
module parity_fir_bank #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int NTAP = 4,
    parameter logic [NTAP*CW-1:0] COEFS = {16'h8000, 16'd1234, -16'sd77, 16'sd5},
    localparam int ZIW = DW + 2,
    localparam int YW  = DW + CW + $clog2(NTAP),
    localparam int ZW  = ZIW + CW + $clog2(NTAP)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [pfb_pkg::NMAIN-1:0][DW-1:0]  x_i,
    input  logic [pfb_pkg::NMAIN-1:0][YW-1:0]  yfault_i,
    input  logic [pfb_pkg::NPAR-1:0][ZW-1:0]   zfault_i,
    output logic                               out_valid,
    output logic [pfb_pkg::NMAIN-1:0][YW-1:0]  y_o,
    output logic                               err_o
);
    import pfb_pkg::*;

    logic [NPAR-1:0][ZIW-1:0] zin;
    logic [NMAIN-1:0][YW-1:0] y_raw, y_hit;
    logic [NPAR-1:0][ZW-1:0]  z_raw, z_hit;
    logic [2:0]               vq;

    pfb_parity_encode #(.DW(DW), .ZW(ZIW)) u_enc (.x(x_i), .zin(zin));

    generate
        for (genvar j = 0; j < NMAIN; j++) begin : g_main
            pfb_fir_lane #(.IW(DW), .CW(CW), .NTAP(NTAP), .COEFS(COEFS)) u_lane (
                .clk(clk), .rst_n(rst_n), .adv(in_valid),
                .x(x_i[j]), .y(y_raw[j])
            );
            assign y_hit[j] = y_raw[j] ^ yfault_i[j];
        end
        for (genvar i = 0; i < NPAR; i++) begin : g_par
            pfb_fir_lane #(.IW(ZIW), .CW(CW), .NTAP(NTAP), .COEFS(COEFS)) u_lane (
                .clk(clk), .rst_n(rst_n), .adv(in_valid),
                .x(zin[i]), .y(z_raw[i])
            );
            assign z_hit[i] = z_raw[i] ^ zfault_i[i];
        end
    endgenerate

    // Delay the sample strobe to match the three filter stages.
    always_ff @(posedge clk) begin
        if (!rst_n) vq <= '0;
        else        vq <= {vq[1:0], in_valid};
    end

    pfb_syndrome_fix #(.YW(YW), .ZW(ZW)) u_fix (
        .clk(clk), .rst_n(rst_n), .vld(vq[2]),
        .y(y_hit), .z(z_hit),
        .y_fix(y_o), .err(err_o), .vld_o(out_valid)
    );
endmodule

// File: rtl/pfb_chk.sv
// Property checker for parity_fir_bank, attached by bind below.
module pfb_chk #(
    parameter int YW = 34,
    parameter int ZW = 36
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               in_valid,
    input logic [pfb_pkg::NMAIN-1:0][YW-1:0]  yfault_i,
    input logic [pfb_pkg::NPAR-1:0][ZW-1:0]   zfault_i,
    input logic                               out_valid,
    input logic                               err_o
);
    logic [3:0] vhist;

    // Track the last four strobes seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vhist <= '0;
        else        vhist <= {vhist[2:0], in_valid};
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !err_o));

    // R3
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vhist[3]);

    // R5
    clean_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (yfault_i == '0 && zfault_i == '0) |=> !err_o);

    // R9
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> out_valid);
endmodule

bind parity_fir_bank pfb_chk #(.YW(YW), .ZW(ZW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .yfault_i(yfault_i), .zfault_i(zfault_i),
    .out_valid(out_valid), .err_o(err_o)
);

// File: tb/parity_fir_bank_bench.sv
module parity_fir_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int YW = 34;
    localparam int ZW = 36;
    localparam int NV = 10;
    // Vector: {exp_err, x0, x1, x2, x3, fault code, mask}; code 0 none, 1..4 data lane, 5..7 check lane.
    localparam logic [100:0] VECS [NV] = '{
        {1'b0, 16'sd100,  16'sd200,  -16'sd300, 16'sd400,  4'd0, 32'h0},
        {1'b0, -16'sd7,   16'sd55,   16'sd1000, -16'sd9,   4'd0, 32'h0},
        {1'b1, 16'sd31,   -16'sd44,  16'sd2,    16'sd600,  4'd1, 32'h0000_0001},
        {1'b1, 16'sd12,   16'sd3,    -16'sd800, 16'sd77,   4'd2, 32'h8000_0000},
        {1'b1, -16'sd500, 16'sd900,  16'sd1,    -16'sd2,   4'd3, 32'h00F0_0F00},
        {1'b1, 16'sd8,    -16'sd8,   16'sd16,   -16'sd16,  4'd4, 32'h1234_5678},
        {1'b1, 16'sd1,    16'sd2,    16'sd3,    16'sd4,    4'd5, 32'h0000_0100},
        {1'b1, 16'h7FFF,  16'h7FFF,  16'h7FFF,  16'h7FFF,  4'd6, 32'hFFFF_FFFF},
        {1'b1, 16'h8000,  16'h8000,  16'h8000,  16'h8000,  4'd7, 32'h0000_0040},
        {1'b0, 16'h8000,  16'h7FFF,  16'h8000,  16'h7FFF,  4'd0, 32'h0}
    };
    localparam longint H [4] = '{5, -77, 1234, -32768};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [3:0][DW-1:0] x_i = '0;
    logic [3:0][YW-1:0] yfault_i = '0;
    logic [2:0][ZW-1:0] zfault_i = '0;
    logic out_valid;
    logic [3:0][YW-1:0] y_o;
    logic err_o;

    longint hist [4][4];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    parity_fir_bank u_parity_fir_bank (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_i(x_i),
        .yfault_i(yfault_i), .zfault_i(zfault_i),
        .out_valid(out_valid), .y_o(y_o), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model_y(input int j);
        longint s = 0;
        for (int k = 0; k < 4; k++) s += H[k] * hist[j][k];
        return s;
    endfunction

    task automatic clear_hist();
        for (int j = 0; j < 4; j++)
            for (int k = 0; k < 4; k++) hist[j][k] = 0;
    endtask

    task automatic check_outputs(input string req, input bit exp_err);
        for (int j = 0; j < 4; j++)
            chk(req, longint'($signed(y_o[j])), model_y(j));
        chk(req, longint'(err_o), longint'(exp_err));
        chk("R3", longint'(out_valid), 1);
    endtask

    // Accept one sample with the given fault, then check at its due edge.
    task automatic send(input logic [3:0][DW-1:0] xs, input int code,
                        input logic [31:0] mask, input bit exp_err, input string req);
        @(negedge clk);
        x_i = xs;
        in_valid = 1'b1;
        yfault_i = '0;
        zfault_i = '0;
        if (code >= 1 && code <= 4) yfault_i[code-1] = YW'(mask);
        if (code >= 5) zfault_i[code-5] = ZW'(mask);
        for (int j = 0; j < 4; j++) begin
            for (int k = 3; k > 0; k--) hist[j][k] = hist[j][k-1];
            hist[j][0] = longint'($signed(xs[j]));
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R3", longint'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        check_outputs(req, exp_err);
        yfault_i = '0;
        zfault_i = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clear_hist();
        // R1: reset with strobe active must not produce output.
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", longint'(out_valid), 0);
        chk("R1", longint'(err_o), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R2 R5 R6 R7 R8: table walk.
        for (int v = 0; v < NV; v++) begin
            logic [3:0][DW-1:0] xs;
            string req;
            int code;
            xs[0] = VECS[v][99:84];
            xs[1] = VECS[v][83:68];
            xs[2] = VECS[v][67:52];
            xs[3] = VECS[v][51:36];
            code  = int'(VECS[v][35:32]);
            if (code == 0)      req = (v >= 7) ? "R8" : "R5";
            else if (code <= 4) req = "R6";
            else                req = "R7";
            if (v < 2) req = "R2";
            send(xs, code, VECS[v][31:0], VECS[v][100], req);
        end

        // R4: idle cycles leave outputs unchanged.
        repeat (6) @(negedge clk);
        for (int j = 0; j < 4; j++) chk("R4", longint'($signed(y_o[j])), model_y(j));
        chk("R4", longint'(out_valid), 0);
        chk("R9", longint'(err_o), 0);

        // R1: mid-run reset clears history.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", longint'(out_valid), 0);
        chk("R1", longint'(err_o), 0);
        rst_n = 1'b1;
        clear_hist();
        send({16'sd400, 16'sd300, 16'sd200, 16'sd100}, 0, 32'h0, 1'b0, "R1");

        // R9: flag falls with valid on the next idle cycle after a faulty sample.
        send({16'sd3, 16'sd2, 16'sd1, 16'sd9}, 2, 32'h0000_0004, 1'b1, "R6");
        @(negedge clk);
        chk("R9", longint'(err_o), 0);
        chk("R9", longint'(out_valid), 0);

        finish_run();
    end
endmodule